// File: doc/BRIEF.md
# Power-Management Register Target on a Two-Wire Bus

This block is a bus target that lets a host processor read the register space of a power-management device over a standard two-wire I2C bus. It watches open-drain clock and data lines that it samples into the core clock domain. It answers to one fixed 7-bit address and can pull the data line low to acknowledge or to send read data. It never drives the clock line.

A write transfer always starts by loading a register pointer from its first data byte. After that, data bytes land only in the single writable voltage-control register. Every other register is read-only, and a byte aimed at one of them is acknowledged and then dropped. A read transfer returns registers one after another from the pointer, which advances by one after each byte until it runs off the end of the register space. The pointer survives STOP and repeated START, so a host can set it in a write and then read back with a repeated START.

Top module: `pm_i2c_target`

## Requirements
- R1: After reset, SDA is released (sda_pull = 0) and the register space reads as zero, except for three entries: index 0x03 reads 0x01, index 0x23 reads 0x16 and index 0x40 reads 0xD8. The pointer starts at 0x00.
- R2: An address byte carries the 7-bit address in bits 7..1 and the direction in bit 0, where 1 means read. The target acknowledges only TARGET_ADDR. For any other address it leaves SDA released during the acknowledge bit, and it acknowledges nothing more until the next START.
- R3: The first data byte written after any START, repeated START or STOP is loaded into the register pointer.
- R4: A later write byte is stored only when the pointer equals 0x23, and the pointer then increments. When the pointer holds any other value, the byte is dropped and both the pointer and the register contents stay as they were.
- R5: While the pointer is below 186, each read byte returns the register at the pointer and then increments the pointer.
- R6: When the pointer is 186 or more, a read byte returns 0xFF and the pointer does not move.
- R7: The pointer keeps its value across STOP, START and repeated START. A later read continues from wherever the last transfer left it.
- R8: Bytes go out MSB first. The target changes SDA only while SCL is low. After the host answers a read byte with NACK, the target releases SDA.
- R9: The target acknowledges every write data byte of an addressed transfer, whether or not it stores the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; it must run well above the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Level of the bus clock line as seen at the pad |
| sda_in | input | 1 | Level of the bus data line as seen at the pad |
| sda_pull | output | 1 | 1 drives the data line low; 0 leaves it to the pull-up |

## Verification
The hardest case to reach is one where the byte counter and the pointer disagree with what the host would naively expect. The test that covers it sets the pointer, ends the transfer with STOP and then writes again. If the STOP had not reset the byte counter, the new first byte would be taken as data, so the bench reads back a distinctive value at the writable register to show it was treated as a pointer. To prove that a dropped byte leaves the pointer where it was, the bench follows such a write with a repeated-START read that sends no new pointer, and the first byte read must come from the old index. The end of the register space is reached by pointing just below the limit and reading across it, followed by a fresh transfer that must still return 0xFF.

// File: rtl/pm_i2c_pkg.sv
// Shared types for the power-management bus target.
package pm_i2c_pkg;

    // Byte-level phase of the bus target.
    typedef enum logic [2:0] {
        ST_IDLE,   // not addressed; waiting for START
        ST_ADDR,   // shifting in the address byte
        ST_ACK,    // target holds the acknowledge bit
        ST_WR,     // shifting in a write data byte
        ST_RD,     // shifting out a read data byte
        ST_RACK    // sampling the host acknowledge of a read byte
    } link_state_t;

endpackage

// File: rtl/pm_i2c_sync.sv
// Bus line conditioner.
// Brings SCL and SDA into the clk domain through a STAGES-deep flop chain.
// From the synchronised levels it derives SCL edges and the START and STOP
// conditions (an SDA edge while SCL stays high).
// Assumes clk is many times faster than SCL. Both lines reset to idle-high.
module pm_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_p;
    logic              sda_p;

    // Synchroniser chains plus one history flop per line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    // Edge and bus-condition decode on the synchronised levels.
    always_comb begin
        scl_s     = scl_ff[STAGES-1];
        sda_s     = sda_ff[STAGES-1];
        scl_rise  = scl_s && !scl_p;
        scl_fall  = !scl_s && scl_p;
        start_det = scl_s && scl_p && sda_p && !sda_s;
        stop_det  = scl_s && scl_p && !sda_p && sda_s;
    end
endmodule

// File: rtl/pm_i2c_link.sv
// Byte engine of the bus target.
// Matches the address, shifts bytes in and out MSB first and drives the
// acknowledge bits. It raises one-cycle strobes toward the register bank:
// wr_en on each complete write byte (wr_is_ptr marks the first byte of a
// transfer) and rd_en whenever a read byte is fetched.
// Assumes rd_data is valid in the same cycle as rd_en.
module pm_i2c_link
    import pm_i2c_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h34
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       wr_en,
    output logic       wr_is_ptr,
    output logic [7:0] wr_data,
    output logic       rd_en,
    output logic       sda_pull
);
    localparam int BITS = 8;

    link_state_t state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        is_read;
    logic        first_byte;
    logic        host_nack;

    // Strobes toward the register bank, issued on the SCL fall that ends a byte.
    always_comb begin
        wr_en     = (state == ST_WR) && scl_fall && (bitcnt == 4'(BITS));
        wr_is_ptr = first_byte;
        wr_data   = shreg;
        rd_en     = scl_fall && (((state == ST_ACK) && is_read) ||
                                 ((state == ST_RACK) && !host_nack));
    end

    // Bus phase sequencing, shifting and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            is_read    <= 1'b0;
            first_byte <= 1'b1;
            host_nack  <= 1'b0;
            sda_pull   <= 1'b0;
        end else if (start_det) begin
            state      <= ST_ADDR;
            bitcnt     <= '0;
            first_byte <= 1'b1;
            sda_pull   <= 1'b0;
        end else if (stop_det) begin
            state      <= ST_IDLE;
            first_byte <= 1'b1;
            sda_pull   <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && bitcnt < 4'(BITS)) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'(BITS)) begin
                        bitcnt <= '0;
                        if (state == ST_WR) begin
                            first_byte <= 1'b0;
                            sda_pull   <= 1'b1;
                            state      <= ST_ACK;
                        end else if (shreg[7:1] == TARGET_ADDR) begin
                            is_read  <= shreg[0];
                            sda_pull <= 1'b1;
                            state    <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (is_read) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            state    <= ST_RD;
                        end else begin
                            sda_pull <= 1'b0;
                            state    <= ST_WR;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'(BITS - 1)) begin
                            bitcnt   <= '0;
                            sda_pull <= 1'b0;
                            state    <= ST_RACK;
                        end else begin
                            shreg    <= {shreg[6:0], 1'b0};
                            sda_pull <= ~shreg[6];
                            bitcnt   <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        host_nack <= sda_s;
                    end else if (scl_fall) begin
                        if (!host_nack) begin
                            shreg    <= rd_data;
                            sda_pull <= ~rd_data[7];
                            state    <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pm_reg_bank.sv
// Register space of the power-management target.
// Holds the register pointer and the one writable register. Every other
// index is a constant: the fixed entries come from parameters and all the
// rest read zero. Indices at or past NUM_REGS read 0xFF.
// Assumes wr_en and rd_en never fire in the same cycle.
module pm_reg_bank #(
    parameter int         NUM_REGS = 186,
    parameter logic [7:0] WR_REG   = 8'h23,
    parameter logic [7:0] WR_RST   = 8'h16,
    parameter logic [7:0] VER_IDX  = 8'h03,
    parameter logic [7:0] VER_VAL  = 8'h01,
    parameter logic [7:0] IRQ_IDX  = 8'h40,
    parameter logic [7:0] IRQ_VAL  = 8'hD8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_is_ptr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);
    localparam int             NFIX      = 2;
    localparam logic [8:0]     LIMIT     = 9'(NUM_REGS);
    localparam logic [NFIX*16-1:0] FIX_TAB = {IRQ_IDX, IRQ_VAL, VER_IDX, VER_VAL};

    logic [7:0]      ptr_q;
    logic [7:0]      vreg_q;
    logic            in_range;
    logic [NFIX-1:0] fix_hit;
    logic [7:0]      fix_val [NFIX];

    assign in_range = {1'b0, ptr_q} < LIMIT;

    // One comparator per read-only constant entry.
    for (genvar g = 0; g < NFIX; g++) begin : g_fixed
        assign fix_hit[g] = (ptr_q == FIX_TAB[g*16+8 +: 8]);
        assign fix_val[g] = FIX_TAB[g*16 +: 8];
    end

    // Pointer load or advance, and the writable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            vreg_q <= WR_RST;
        end else if (wr_en) begin
            if (wr_is_ptr) begin
                ptr_q <= wr_data;
            end else if (ptr_q == WR_REG) begin
                vreg_q <= wr_data;
                ptr_q  <= ptr_q + 8'd1;
            end
        end else if (rd_en && in_range) begin
            ptr_q <= ptr_q + 8'd1;
        end
    end

    // Read value selection at the current pointer.
    always_comb begin
        rd_data = '0;
        if (!in_range) begin
            rd_data = 8'hFF;
        end else if (ptr_q == WR_REG) begin
            rd_data = vreg_q;
        end else begin
            for (int i = 0; i < NFIX; i++) begin
                if (fix_hit[i]) rd_data = fix_val[i];
            end
        end
    end
endmodule

// File: rtl/pm_i2c_target.sv
// Top of the power-management bus target.
// Chains the line conditioner, the byte engine and the register bank.
// Assumes external pull-ups, with sda_pull driving an open-drain pad. SCL is
// only observed, never held low.
module pm_i2c_target #(
    parameter logic [6:0] TARGET_ADDR = 7'h34,
    parameter int         NUM_REGS    = 186,
    parameter logic [7:0] WR_REG      = 8'h23,
    parameter logic [7:0] WR_RST      = 8'h16,
    parameter logic [7:0] VER_IDX     = 8'h03,
    parameter logic [7:0] VER_VAL     = 8'h01,
    parameter logic [7:0] IRQ_IDX     = 8'h40,
    parameter logic [7:0] IRQ_VAL     = 8'hD8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull
);
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_en;
    logic       wr_is_ptr;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;

    pm_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pm_i2c_link #(.TARGET_ADDR(TARGET_ADDR)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_is_ptr (wr_is_ptr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .sda_pull  (sda_pull)
    );

    pm_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .WR_REG   (WR_REG),
        .WR_RST   (WR_RST),
        .VER_IDX  (VER_IDX),
        .VER_VAL  (VER_VAL),
        .IRQ_IDX  (IRQ_IDX),
        .IRQ_VAL  (IRQ_VAL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_is_ptr (wr_is_ptr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/pm_i2c_target_chk.sv
// Property checker for pm_i2c_target, attached to it with bind.
// It sees the strobes between the byte engine and the register bank, the
// pointer and the writable register, and it checks how they relate over time.
module pm_i2c_target_chk #(
    parameter int         NUM_REGS = 186,
    parameter logic [7:0] WR_REG   = 8'h23
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_pull,
    input logic       wr_en,
    input logic       wr_is_ptr,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic [7:0] ptr,
    input logic [7:0] vreg
);
    localparam logic [8:0] LIMIT = 9'(NUM_REGS);

    AST_RESET_RELEASE: assert property (@(posedge clk)
        !rst_n |=> !sda_pull); // R1

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_is_ptr |=> ptr == $past(wr_data)); // R3

    AST_WR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_is_ptr && (ptr != WR_REG) |=> $stable(ptr) && $stable(vreg)); // R4

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ({1'b0, ptr} < LIMIT) |=> ptr == $past(ptr) + 8'd1); // R5

    AST_READ_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && ({1'b0, ptr} >= LIMIT) |=> $stable(ptr)); // R6

    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)
        |-> $stable(sda_pull)); // R8
endmodule

bind pm_i2c_target pm_i2c_target_chk #(
    .NUM_REGS (NUM_REGS),
    .WR_REG   (WR_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en),
    .wr_is_ptr (wr_is_ptr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .ptr       (u_bank.ptr_q),
    .vreg      (u_bank.vreg_q)
);

// File: tb/pm_i2c_target_test.sv
// Scoreboard bench. The bus-host tasks queue expected read bytes, the read
// task queues observed bytes, and a monitor process pairs them up.
module pm_i2c_target_test;
    localparam int         Q    = 10;      // core clocks per quarter bit
    localparam logic [6:0] ADDR = 7'h34;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    pm_i2c_target uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_pull (sda_pull)
    );

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] obs_q [$];
    logic [7:0] mon_obs;
    logic [7:0] mon_exp;
    string      mon_tag;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait(); qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        b = sda_line; qwait(); scl_m = 1'b0; qwait();
    endtask

    // Sends one byte MSB first and checks the acknowledge bit (0 on the line = ACK).
    task automatic write_byte(input logic [7:0] v, input bit exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        check(a == !exp_ack, tag, a, !exp_ack);
    endtask

    // Receives one byte MSB first for the scoreboard, then sends ACK or NACK.
    task automatic read_byte(input bit last);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        obs_q.push_back(v);
        send_bit(last);
    endtask

    task automatic expect_rd(input logic [7:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares each observed read byte with the next expected one.
    initial begin
        forever begin
            wait (obs_q.size() > 0);
            mon_obs = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                check(1'b0, "SCOREBOARD unexpected byte", mon_obs, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_tag = tag_q.pop_front();
                check(mon_obs == mon_exp, mon_tag, mon_obs, mon_exp);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG run hung", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        check(sda_pull == 1'b0, "R1 SDA released in reset", sda_pull, 0);
        rst_n = 1'b1;
        qwait();
        check(sda_pull == 1'b0, "R1 SDA released after reset", sda_pull, 0);

        // R1 R5: read 0x00..0x03 from the reset pointer.
        expect_rd(8'h00, "R1 R5 idx 0x00");
        expect_rd(8'h00, "R1 R5 idx 0x01");
        expect_rd(8'h00, "R1 R5 idx 0x02");
        expect_rd(8'h01, "R1 R5 idx 0x03 version");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack own read address");
        read_byte(0); read_byte(0); read_byte(0); read_byte(1);
        qwait();
        check(sda_pull == 1'b0, "R8 released after host NACK", sda_pull, 0);
        bus_stop();

        // R7: pointer set by a write, read back after a repeated START.
        expect_rd(8'h00, "R7 idx 0x22");
        expect_rd(8'h16, "R1 idx 0x23 reset value");
        expect_rd(8'h00, "R5 idx 0x24");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack own write address");
        write_byte(8'h22, 1, "R9 ack pointer byte");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack read after rstart");
        read_byte(0); read_byte(0); read_byte(1);
        bus_stop();

        // R7: a new transfer continues from 0x25.
        expect_rd(8'h00, "R7 idx 0x25 after stop");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(1);
        bus_stop();

        // R1 R8: 0x3F then 0xD8, an asymmetric value that checks MSB-first order.
        expect_rd(8'h00, "R1 idx 0x3F");
        expect_rd(8'hD8, "R1 R8 idx 0x40");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h3F, 1, "R9 ack");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(0); read_byte(1);
        bus_stop();

        // R4: bytes at pointer 0x22 are dropped and the pointer holds.
        expect_rd(8'h00, "R4 pointer held at 0x22");
        expect_rd(8'h16, "R4 idx 0x23 not written");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h22, 1, "R9 ack");
        write_byte(8'h77, 1, "R9 ack dropped byte");
        write_byte(8'h66, 1, "R9 ack dropped byte");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(0); read_byte(1);
        bus_stop();

        // R4: 0x23 stores the byte and advances; the next byte is dropped.
        expect_rd(8'hA5, "R4 idx 0x23 written");
        expect_rd(8'h00, "R4 idx 0x24 untouched");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h23, 1, "R9 ack");
        write_byte(8'hA5, 1, "R9 ack stored byte");
        write_byte(8'h5A, 1, "R9 ack dropped byte");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h23, 1, "R3 ack pointer after rstart");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(0); read_byte(1);
        bus_stop();

        // R4 R7: a write to read-only 0x40 leaves the pointer there.
        expect_rd(8'hD8, "R4 R7 idx 0x40 unchanged");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h40, 1, "R9 ack");
        write_byte(8'h55, 1, "R9 ack dropped byte");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(1);
        bus_stop();

        // R3: STOP resets the byte counter, so 0x23 becomes a pointer again.
        expect_rd(8'hC3, "R3 first byte after stop is pointer");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h23, 1, "R9 ack");
        bus_stop();
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h23, 1, "R3 ack");
        write_byte(8'hC3, 1, "R9 ack");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'h23, 1, "R3 ack");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(1);
        bus_stop();

        // R6: read across the end of the register space.
        expect_rd(8'h00, "R5 idx 0xB8");
        expect_rd(8'h00, "R5 idx 0xB9 last");
        expect_rd(8'hFF, "R6 past end");
        expect_rd(8'hFF, "R6 past end held");
        bus_start();
        write_byte({ADDR, 1'b0}, 1, "R2 ack");
        write_byte(8'hB8, 1, "R9 ack");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(0); read_byte(0); read_byte(0); read_byte(1);
        bus_stop();
        expect_rd(8'hFF, "R6 R7 pointer still past end");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(1);
        bus_stop();

        // R2: a foreign address is NACKed and the bytes after it are ignored.
        bus_start();
        write_byte({7'h35, 1'b0}, 0, "R2 NACK foreign address");
        write_byte(8'h03, 0, "R2 ignored after foreign address");
        bus_stop();
        expect_rd(8'hFF, "R2 pointer not loaded by foreign transfer");
        bus_start();
        write_byte({ADDR, 1'b1}, 1, "R2 ack");
        read_byte(1);
        bus_stop();

        wait (obs_q.size() == 0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "SCOREBOARD leftover expects", exp_q.size(), 0);
        finish_run();
    end
endmodule